// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital side of a two-channel digital-to-analog converter of 8, 10 or 12 bits. A host talks to it over a SPI-style link: an active-low chip select frames each 16-bit word, the word arrives most-significant bit first on the data input, and a serial clock marks the bits. The upper four bits of a word are a command and the lower twelve bits are data. Each channel keeps a staging register and an output register, and the output registers drive the converter codes.

The commands cover several jobs. A host can stage a code, stage and apply a code in one step, or ask for a staged value to be returned on the serial output during the following frame. It can also do nothing, or write a small configuration register. That register sets how the serial output pin is driven, turns on pass-through cascading of several devices, chooses the target of the hardware clear input and picks the serial clock edge used to sample data. All serial inputs are treated as signals synchronous to the system clock, and clock edges are found by comparing against a registered copy.

Top module: `dacif_top`

## Requirements
- R1: A frame is accepted only when chip select rises after exactly 16 sampling edges. It is shifted in most-significant bit first, with the command in bits [15:12] and data in bits [11:0]. Frames of 15 or 17 bits change nothing.
- R2: Command 1+3x (1 for channel 0, 4 for channel 1) writes the data into both the staging and the output register of channel x. The output code changes on the first system clock edge after chip select rises.
- R3: Command 3+3x (3 for channel 0, 6 for channel 1) writes only the staging register of channel x. Its output code stays the same.
- R4: The code is left-aligned in the data field and taken from bits [11:12-RES]. The lower 12-RES bits are ignored.
- R5: After command 2+3x (2 for channel 0, 5 for channel 1), the next frame shifts out on the serial output, MSB first, a 16-bit word: four zero bits, then the staging register of channel x left-aligned in the low 12 bits. In a frame that does not follow a read command, zeros are shifted out.
- R6: Command 13 stores data bits [11:7] into the configuration register. Command 0 and the unused codes 7 to 12, 14 and 15 leave every register unchanged.
- R7: Configuration bits [11:10] set the output mode. Modes 0 and 1 drive the output whenever chip select is low. Mode 2 enables the output only while its data bit is 0. Mode 3 never enables it. The output is never enabled while chip select is high.
- R8: When configuration bit 9 is set, the serial output carries the input bits delayed by 16 sampling edges, with zeros for the first 16. Frames longer than 16 bits are then accepted, and the last 16 bits are used.
- R9: While the clear input is low, both output codes are forced to zero when configuration bit 8 is 0, or to midscale (1 shifted left by RES-1) when it is 1. Clear takes priority over frames, and staging registers keep their values.
- R10: Configuration bit 7 selects the sampling edge: 1 means the rising serial clock edge and 0 means the falling edge.
- R11: After reset, all codes, staging registers and the configuration register are zero, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_n_i | input | 1 | Chip select, active low, frames a word |
| sdi_i | input | 1 | Serial data in, MSB first |
| clr_n_i | input | 1 | Hardware clear, active low, level sensitive |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out enable |
| dac_code_o | output | NCH*RES | Output codes, channel 0 in the low RES bits |

## Verification
The output codes change on the first system clock edge after chip select rises, so the bench waits three clock cycles after releasing chip select before it compares the codes. An output data bit moves one clock cycle after the sampling edge that shifts it. The bench therefore reads the output value and its enable two cycles after presenting each new input bit and before it toggles the serial clock, so each reading falls between two edges. The clear input acts one cycle after it falls, and its result is compared three cycles later, while clear is still low, and again after it is released. All samples are taken on the falling edge of the system clock.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = 12;

    typedef enum logic [1:0] {
        SDO_FULL = 2'd0,
        SDO_WEAK = 2'd1,
        SDO_OPEN = 2'd2,
        SDO_OFF  = 2'd3
    } sdo_mode_e;

    // Field order matches data bits [11:7] of a configuration write
    typedef struct packed {
        sdo_mode_e mode;
        logic      chain;
        logic      clr_mid;
        logic      rise_edge;
    } ctrl_t;

    localparam logic [CMD_W-1:0] CMD_NOP  = 4'd0;
    localparam logic [CMD_W-1:0] CMD_CTRL = 4'd13;
endpackage

// File: rtl/dacif_shifter.sv
module dacif_shifter
    import dacif_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sclk_i,
    input  logic               cs_n_i,
    input  logic               sdi_i,
    input  logic               rise_edge_i,
    input  logic               chain_i,
    output logic               shift_o,
    output logic               cs_rise_o,
    output logic               frm_vld_o,
    output logic [FRAME_W-1:0] frm_word_o,
    output logic               chain_bit_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sclk;
        logic               cs_n;
        logic [FRAME_W-1:0] sreg;
        logic [CNT_W-1:0]   cnt;
    } shf_t;

    shf_t s_d, s_q;
    logic rise, fall, samp, cs_fall, cs_rise;

    always_comb begin
        s_d      = s_q;
        s_d.sclk = sclk_i;
        s_d.cs_n = cs_n_i;
        rise     = sclk_i & ~s_q.sclk;
        fall     = ~sclk_i & s_q.sclk;
        samp     = ~cs_n_i & (rise_edge_i ? rise : fall);
        cs_fall  = ~cs_n_i & s_q.cs_n;
        cs_rise  = cs_n_i & ~s_q.cs_n;
        if (cs_fall) begin
            s_d.sreg = '0;
            s_d.cnt  = '0;
        end else if (samp) begin
            s_d.sreg = {s_q.sreg[FRAME_W-2:0], sdi_i};
            if (s_q.cnt != CNT_OVER) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{sclk: 1'b1, cs_n: 1'b1, sreg: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign shift_o     = samp;
    assign cs_rise_o   = cs_rise;
    assign frm_vld_o   = cs_rise & ((s_q.cnt == CNT_FULL) | (chain_i & (s_q.cnt == CNT_OVER)));
    assign frm_word_o  = s_q.sreg;
    assign chain_bit_o = s_q.sreg[FRAME_W-1];
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int NCH = 2,
    parameter int RES = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frm_vld_i,
    input  logic [FRAME_W-1:0] frm_word_i,
    input  logic               clr_n_i,
    output ctrl_t              ctrl_o,
    output logic [NCH*RES-1:0] dac_o,
    output logic               rb_en_o,
    output logic [FRAME_W-1:0] rb_word_o
);
    localparam logic [RES-1:0] MID = RES'(1) << (RES - 1);

    typedef logic [NCH-1:0][RES-1:0] chan_arr_t;
    typedef struct packed {
        ctrl_t     ctrl;
        chan_arr_t inr;
        chan_arr_t dac;
    } reg_t;

    reg_t r_d, r_q;
    logic [CMD_W-1:0] cmd;
    logic [RES-1:0]   code;
    logic [NCH-1:0]   upd_hit, ld_hit, rd_hit;
    logic [DATA_W-1:0] rb_al;
    logic             frm_unused;

    assign cmd        = frm_word_i[FRAME_W-1 -: CMD_W];
    assign code       = frm_word_i[DATA_W-1 -: RES];
    assign frm_unused = ^frm_word_i[6:0];

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign upd_hit[g] = frm_vld_i & (cmd == CMD_W'(1 + 3 * g));
        assign rd_hit[g]  = frm_vld_i & (cmd == CMD_W'(2 + 3 * g));
        assign ld_hit[g]  = frm_vld_i & (cmd == CMD_W'(3 + 3 * g));
    end

    always_comb begin
        r_d = r_q;
        if (frm_vld_i && cmd == CMD_CTRL) begin
            r_d.ctrl = ctrl_t'(frm_word_i[11:7]);
        end
        for (int c = 0; c < NCH; c++) begin
            if (upd_hit[c]) begin
                r_d.inr[c] = code;
                r_d.dac[c] = code;
            end
            if (ld_hit[c]) begin
                r_d.inr[c] = code;
            end
            if (!clr_n_i) begin
                r_d.dac[c] = r_q.ctrl.clr_mid ? MID : '0;
            end
        end
    end

    always_comb begin
        rb_al = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_hit[c]) begin
                rb_al[DATA_W-1 -: RES] = r_q.inr[c];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_o    = r_q.ctrl;
    assign dac_o     = r_q.dac;
    assign rb_en_o   = |rd_hit;
    assign rb_word_o = {{(FRAME_W-DATA_W){1'b0}}, rb_al};
endmodule

// File: rtl/dacif_sdo.sv
module dacif_sdo
    import dacif_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cs_n_i,
    input  logic               cs_rise_i,
    input  logic               shift_i,
    input  logic               load_en_i,
    input  logic [FRAME_W-1:0] load_word_i,
    input  logic               chain_i,
    input  logic               chain_bit_i,
    input  sdo_mode_e          mode_i,
    output logic               sdo_o,
    output logic               sdo_oe_o
);
    logic [FRAME_W-1:0] out_d, out_q;
    logic               bit_val;

    always_comb begin
        out_d = out_q;
        if (cs_rise_i) begin
            out_d = load_en_i ? load_word_i : '0;
        end else if (shift_i) begin
            out_d = {out_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bit_val = chain_i ? chain_bit_i : out_q[FRAME_W-1];

    always_comb begin
        unique case (mode_i)
            SDO_FULL, SDO_WEAK: sdo_oe_o = ~cs_n_i;
            SDO_OPEN:           sdo_oe_o = ~cs_n_i & ~bit_val;
            default:            sdo_oe_o = 1'b0;
        endcase
    end

    assign sdo_o = bit_val;
endmodule

// File: rtl/dacif_top.sv
module dacif_top
    import dacif_pkg::*;
#(
    parameter int NCH = 2,
    parameter int RES = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sclk_i,
    input  logic               cs_n_i,
    input  logic               sdi_i,
    input  logic               clr_n_i,
    output logic               sdo_o,
    output logic               sdo_oe_o,
    output logic [NCH*RES-1:0] dac_code_o
);
    ctrl_t              ctrl_q;
    logic               shift, cs_rise, frm_vld, chain_bit, rb_en;
    logic [FRAME_W-1:0] frm_word, rb_word;

    dacif_shifter u_shf (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_i      (sclk_i),
        .cs_n_i      (cs_n_i),
        .sdi_i       (sdi_i),
        .rise_edge_i (ctrl_q.rise_edge),
        .chain_i     (ctrl_q.chain),
        .shift_o     (shift),
        .cs_rise_o   (cs_rise),
        .frm_vld_o   (frm_vld),
        .frm_word_o  (frm_word),
        .chain_bit_o (chain_bit)
    );

    dacif_regs #(.NCH(NCH), .RES(RES)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .frm_vld_i  (frm_vld),
        .frm_word_i (frm_word),
        .clr_n_i    (clr_n_i),
        .ctrl_o     (ctrl_q),
        .dac_o      (dac_code_o),
        .rb_en_o    (rb_en),
        .rb_word_o  (rb_word)
    );

    dacif_sdo u_sdo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_n_i      (cs_n_i),
        .cs_rise_i   (cs_rise),
        .shift_i     (shift),
        .load_en_i   (rb_en),
        .load_word_i (rb_word),
        .chain_i     (ctrl_q.chain),
        .chain_bit_i (chain_bit),
        .mode_i      (ctrl_q.mode),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o)
    );
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker
    import dacif_pkg::*;
#(
    parameter int NCH = 2,
    parameter int RES = 12
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cs_n_i,
    input logic               clr_n_i,
    input logic               sdo_o,
    input logic               sdo_oe_o,
    input logic [NCH*RES-1:0] dac_code_o,
    input ctrl_t              ctrl_i,
    input logic               frm_vld_i,
    input logic [FRAME_W-1:0] frm_word_i
);
    localparam logic [RES-1:0] MID = RES'(1) << (RES - 1);

    AST_FRAME_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frm_vld_i |-> (cs_n_i && $past(!cs_n_i))); // R1

    AST_HOLD_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frm_vld_i && clr_n_i) |=> $stable(dac_code_o)); // R6

    for (genvar g = 0; g < NCH; g++) begin : g_ld
        AST_LOAD_ONLY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (frm_vld_i && clr_n_i && frm_word_i[15:12] == 4'(3 + 3 * g))
            |=> $stable(dac_code_o[g*RES +: RES])); // R3
    end

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_i |-> !sdo_oe_o); // R7

    AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i.mode == SDO_OFF) |-> !sdo_oe_o); // R7

    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i.mode == SDO_OPEN && sdo_oe_o) |-> !sdo_o); // R7

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_n_i && !ctrl_i.clr_mid) |=> (dac_code_o == '0)); // R9

    AST_CLEAR_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_n_i && ctrl_i.clr_mid) |=> (dac_code_o == {NCH{MID}})); // R9
endmodule

bind dacif_top dacif_checker #(.NCH(NCH), .RES(RES)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_i),
    .clr_n_i    (clr_n_i),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .dac_code_o (dac_code_o),
    .ctrl_i     (ctrl_q),
    .frm_vld_i  (frm_vld),
    .frm_word_i (frm_word)
);

// File: tb/dacif_tb_top.sv
`timescale 1ns/1ps
module dacif_top_tb_top;
    localparam int NCH = 2;
    localparam int RES = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, clr_n = 1'b1;
    logic sdo, sdo_oe;
    logic [NCH*RES-1:0] dac;
    int   total = 0, bad = 0;
    bit   done = 1'b0;
    logic [31:0] rx, oe;

    always #4 clk = ~clk;

    dacif_top #(.NCH(NCH), .RES(RES)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sclk_i     (sclk),
        .cs_n_i     (cs_n),
        .sdi_i      (sdi),
        .clr_n_i    (clr_n),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .dac_code_o (dac)
    );

    typedef struct packed {
        logic [15:0]    w;
        logic [RES-1:0] e0;
        logic [RES-1:0] e1;
    } vec_t;

    // codes are data >> 2 for a 10-bit resolution
    localparam vec_t VEC [9] = '{
        '{16'h1123, 10'h048, 10'h000},  // R2 ch0 update
        '{16'h4ABC, 10'h048, 10'h2AF},  // R2 ch1 update
        '{16'h3555, 10'h048, 10'h2AF},  // R3 ch0 stage only
        '{16'h0FFF, 10'h048, 10'h2AF},  // R6 no-op
        '{16'h6777, 10'h048, 10'h2AF},  // R3 ch1 stage only
        '{16'h7FFF, 10'h048, 10'h2AF},  // R6 unused code
        '{16'h1802, 10'h200, 10'h2AF},  // R4 low bits dropped
        '{16'hF3C4, 10'h200, 10'h2AF},  // R6 unused code
        '{16'hE000, 10'h200, 10'h2AF}   // R6 unused code
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] wa, input logic [31:0] wb, input int nbits);
        rx = '0;
        oe = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(2);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = wa[i];
            wait_clk(2);
            rx = {rx[30:0], sdo};
            oe = {oe[30:0], sdo_oe};
            sclk = 1'b0;
            wait_clk(2);
            sdi = wb[i];
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(2);
        end
        cs_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic frame(input logic [15:0] w);
        xfer({16'h0, w}, {16'h0, w}, 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        check("R11 codes after reset", 32'(dac), 32'h0);
        check("R11 enable after reset", 32'(sdo_oe), 32'h0);

        for (int k = 0; k < 9; k++) begin
            frame(VEC[k].w);
            check("R2/R3/R4/R6 vector ch0", 32'(dac[RES-1:0]), 32'(VEC[k].e0));
            check("R2/R3/R4/R6 vector ch1", 32'(dac[2*RES-1:RES]), 32'(VEC[k].e1));
        end
        // R7 mode 0 drives during a frame
        check("R7 full drive enable", oe & 32'hFFFF, 32'hFFFF);

        // R5 readback of ch1 staging (0x1DD left aligned) and ch0 (0x200)
        frame(16'h5000);
        frame(16'h0000);
        check("R5 readback ch1", rx & 32'hFFFF, 32'h0774);
        frame(16'h2000);
        frame(16'h0000);
        check("R5 readback ch0", rx & 32'hFFFF, 32'h0800);
        frame(16'h0000);
        check("R5 zeros without read", rx & 32'hFFFF, 32'h0000);

        // R1 wrong length frames
        xfer(32'h1FFF, 32'h1FFF, 15);
        check("R1 15-bit frame ignored", 32'(dac[RES-1:0]), 32'h200);
        xfer(32'h013FF, 32'h013FF, 17);
        check("R1 17-bit frame ignored", 32'(dac[RES-1:0]), 32'h200);
        check("R1 ch1 untouched", 32'(dac[2*RES-1:RES]), 32'h2AF);

        // R7 open drain
        frame(16'hD800);
        frame(16'h5000);
        frame(16'h0000);
        check("R7 open drain data", rx & 32'hFFFF, 32'h0774);
        check("R7 open drain enable", oe & 32'hFFFF, ~32'h0774 & 32'hFFFF);
        // R7 disabled
        frame(16'hDC00);
        frame(16'h5000);
        frame(16'h0000);
        check("R7 disabled enable", oe & 32'hFFFF, 32'h0);
        frame(16'hD000);

        // R9 clear to zero
        @(negedge clk);
        clr_n = 1'b0;
        wait_clk(3);
        check("R9 clear zero", 32'(dac), 32'h0);
        clr_n = 1'b1;
        wait_clk(3);
        check("R9 zero kept after release", 32'(dac), 32'h0);
        frame(16'h5000);
        frame(16'h0000);
        check("R9 staging kept", rx & 32'hFFFF, 32'h0774);
        // R9 clear to midscale
        frame(16'hD100);
        frame(16'h1123);
        @(negedge clk);
        clr_n = 1'b0;
        wait_clk(3);
        check("R9 clear midscale", 32'(dac), {12'h0, 10'h200, 10'h200});
        clr_n = 1'b1;
        wait_clk(2);

        // R10 sampling edge
        frame(16'hD080);
        xfer(32'h1000, 32'h1FFC, 16);
        check("R10 rising edge sample", 32'(dac[RES-1:0]), 32'h3FF);
        frame(16'hD000);
        xfer(32'h1004, 32'h1FFC, 16);
        check("R10 falling edge sample", 32'(dac[RES-1:0]), 32'h001);

        // R8 daisy chain
        frame(16'hD200);
        xfer(32'h1ABC_4123, 32'h1ABC_4123, 32);
        check("R8 chain first half zero", rx >> 16, 32'h0);
        check("R8 chain passes word", rx & 32'hFFFF, 32'h1ABC);
        check("R8 last word applied ch1", 32'(dac[2*RES-1:RES]), 32'h048);
        check("R8 ch0 untouched", 32'(dac[RES-1:0]), 32'h001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule